// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Generator

This block produces the two threshold flags of a dual-clock FIFO: an almost-empty flag in the read-clock domain and an almost-full flag in the write-clock domain. The FIFO storage and pointers live elsewhere. The block receives a word count that is already synchronized to the read clock and a free-slot count that is already synchronized to the write clock. It compares each count against its own programmable offset. The empty-side offset is X and the full-side offset is Y.

The two offsets are programmed once per reset, in one of three ways. Two select pins are sampled while reset is held, and the value seen on the cycle reset is released is kept until the next reset. The first way loads a fixed preset into both offsets. The second takes the first two port-A writes after reset as offset values. The third shifts a bit stream into a single chain made of Y followed by X, on the write clock. The select pins are dual-purpose: after reset, in serial mode, they act as the serial enable and the serial data input.

Top module: `almost_flag_offsets`

## Requirements
- R1: The mode is taken from `{sel_hi_sen_n, sel_lo_sdat}` on the last write-clock edge with `rst_n` low, and pin changes after that have no effect on the mode. The encoding is 2'b00 serial, 2'b01 parallel, 2'b10 preset-low and 2'b11 preset-high.
- R2: In preset-low mode both X and Y equal PRESET_LO (default 8). In preset-high mode both equal PRESET_HI (default 16). The values apply from the first cycle after reset.
- R3: In parallel mode, the first `a_wr` after reset loads Y from `a_data[OW-1:0]` and the second loads X from `a_data[OW-1:0]`. The upper data bits are ignored.
- R4: `a_fifo_wr` follows `a_wr` only once programming is complete. It is low for the two offset-loading writes in parallel mode and for every write before the last serial bit in serial mode. Once high-capable, the configuration stays complete until the next reset.
- R5: In serial mode, each write-clock edge with `sel_hi_sen_n` low shifts `sel_lo_sdat` into the {Y,X} chain. A full program takes 2*OW bits: the first is the MSB of Y and the last is the LSB of X.
- R6: After 2*OW serial bits, further low pulses on `sel_hi_sen_n` leave X and Y unchanged until the next reset.
- R7: `almost_empty_n` is low exactly when `word_cnt <= X`, as seen two read-clock edges earlier.
- R8: `almost_full_n` is low exactly when `free_cnt <= Y`, as seen two write-clock edges earlier.
- R9: While in reset, both flags are low. In parallel and serial modes, X and Y are zero until they are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| sel_hi_sen_n | input | 1 | Mode select high bit during reset; serial enable (active low) afterwards |
| sel_lo_sdat | input | 1 | Mode select low bit during reset; serial data afterwards |
| a_wr | input | 1 | Port-A write strobe |
| a_data | input | DW | Port-A write data |
| word_cnt | input | AW+1 | Stored word count, in the clk_b domain |
| free_cnt | input | AW+1 | Free slot count, in the clk_a domain |
| a_fifo_wr | output | 1 | Port-A write forwarded to the FIFO |
| almost_empty_n | output | 1 | Almost-empty flag, active low, clk_b domain |
| almost_full_n | output | 1 | Almost-full flag, active low, clk_a domain |

## Verification
On every cycle, the assertions check that each flag is the two-cycle-delayed comparison of its count against its offset. They also check that the latched mode never moves outside reset, that the preset-high values hold, and that the offsets freeze and completion stays set once programming ends. Only the bench scenarios can show the following: the bit order of the serial stream, which parallel write lands in which offset, that writes are held back during programming, and that pin activity after reset leaves the mode and offsets alone. The bench does this by sweeping every count value against the expected threshold in each mode.

// File: rtl/almost_cfg_pkg.sv
// Shared encoding of the offset programming method.
package almost_cfg_pkg;
    typedef enum logic [1:0] {
        MODE_SERIAL    = 2'b00,
        MODE_PARALLEL  = 2'b01,
        MODE_PRESET_LO = 2'b10,
        MODE_PRESET_HI = 2'b11
    } cfg_mode_e;
endpackage

// File: rtl/offset_loader.sv
// Offset loader: holds the {Y,X} offset chain in the write-clock domain.
// Latches the mode from the select pins while reset is low, then programs
// the chain by preset, by two port-A writes, or by a serial bit stream.
// Assumes DW >= OW. Once done, the chain stays frozen until the next reset.
module offset_loader
    import almost_cfg_pkg::*;
#(
    parameter int DW        = 36,
    parameter int OW        = 10,
    parameter int PRESET_LO = 8,
    parameter int PRESET_HI = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_hi_sen_n,
    input  logic          sel_lo_sdat,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output cfg_mode_e     mode,
    output logic [OW-1:0] x_off,
    output logic [OW-1:0] y_off,
    output logic          done
);
    localparam int SBITS = 2 * OW;
    localparam int CNTW  = $clog2(SBITS + 1);
    localparam logic [OW-1:0] PL = OW'(PRESET_LO);
    localparam logic [OW-1:0] PH = OW'(PRESET_HI);

    cfg_mode_e        mode_q;
    logic [SBITS-1:0] chain_q;
    logic [CNTW-1:0]  bit_cnt_q;
    logic             y_seen_q;
    logic             done_q;

    // Chain, mode latch and progress tracking for all programming methods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= cfg_mode_e'({sel_hi_sen_n, sel_lo_sdat});
            bit_cnt_q <= '0;
            y_seen_q  <= 1'b0;
            done_q    <= sel_hi_sen_n;
            case ({sel_hi_sen_n, sel_lo_sdat})
                2'b10:   chain_q <= {PL, PL};
                2'b11:   chain_q <= {PH, PH};
                default: chain_q <= '0;
            endcase
        end else if (!done_q) begin
            case (mode_q)
                MODE_SERIAL: begin
                    if (!sel_hi_sen_n) begin
                        chain_q   <= {chain_q[SBITS-2:0], sel_lo_sdat};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (bit_cnt_q == CNTW'(SBITS - 1)) done_q <= 1'b1;
                    end
                end
                MODE_PARALLEL: begin
                    if (wr_en) begin
                        if (!y_seen_q) begin
                            chain_q[SBITS-1:OW] <= wr_data[OW-1:0];
                            y_seen_q            <= 1'b1;
                        end else begin
                            chain_q[OW-1:0] <= wr_data[OW-1:0];
                            done_q          <= 1'b1;
                        end
                    end
                end
                default: done_q <= 1'b1;
            endcase
        end
    end

    assign mode  = mode_q;
    assign y_off = chain_q[SBITS-1:OW];
    assign x_off = chain_q[OW-1:0];
    assign done  = done_q;
endmodule

// File: rtl/almost_flag.sv
// Threshold flag: compares a count with an offset in the local clock domain
// and passes the result through STAGES flops. Active-low output; asserted
// (low) during reset. Assumes the offset is quasi-static once programmed.
module almost_flag #(
    parameter int LW     = 11,
    parameter int OW     = 10,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [OW-1:0] thresh,
    output logic          flag_n
);
    logic              raw;
    logic [STAGES-1:0] pipe_q;

    // Compare the count against the zero-extended offset.
    always_comb raw = (level <= LW'(thresh));

    // Two-stage (or STAGES-stage) pipeline onto the local clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], raw};
    end

    assign flag_n = ~pipe_q[STAGES-1];
endmodule

// File: rtl/almost_flag_offsets.sv
// Top: programmable almost-empty / almost-full flag generator.
// The offsets live in the clk_a domain. The almost-empty flag reads X from
// clk_b and assumes X does not change while the flag is in use.
module almost_flag_offsets
    import almost_cfg_pkg::*;
#(
    parameter int DW        = 36,
    parameter int DEPTH     = 1024,
    parameter int PRESET_LO = 8,
    parameter int PRESET_HI = 16
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic          sel_hi_sen_n,
    input  logic          sel_lo_sdat,
    input  logic          a_wr,
    input  logic [DW-1:0] a_data,
    input  logic [$clog2(DEPTH):0] word_cnt,
    input  logic [$clog2(DEPTH):0] free_cnt,
    output logic          a_fifo_wr,
    output logic          almost_empty_n,
    output logic          almost_full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int OW = AW;

    cfg_mode_e     cfg_mode;
    logic [OW-1:0] x_off;
    logic [OW-1:0] y_off;
    logic          cfg_done;

    offset_loader #(.DW(DW), .OW(OW), .PRESET_LO(PRESET_LO), .PRESET_HI(PRESET_HI)) i_loader (
        .clk(clk_a), .rst_n(rst_n), .sel_hi_sen_n(sel_hi_sen_n), .sel_lo_sdat(sel_lo_sdat),
        .wr_en(a_wr), .wr_data(a_data), .mode(cfg_mode), .x_off(x_off), .y_off(y_off),
        .done(cfg_done)
    );

    almost_flag #(.LW(CW), .OW(OW), .STAGES(2)) i_empty (
        .clk(clk_b), .rst_n(rst_n), .level(word_cnt), .thresh(x_off), .flag_n(almost_empty_n)
    );

    almost_flag #(.LW(CW), .OW(OW), .STAGES(2)) i_full (
        .clk(clk_a), .rst_n(rst_n), .level(free_cnt), .thresh(y_off), .flag_n(almost_full_n)
    );

    // Writes reach the FIFO only after the offsets are programmed.
    assign a_fifo_wr = a_wr & cfg_done;
endmodule

// File: rtl/almost_flag_offsets_chk.sv
// Checker for almost_flag_offsets; attached with bind below.
module almost_flag_offsets_chk
    import almost_cfg_pkg::*;
#(
    parameter int CW        = 11,
    parameter int OW        = 10,
    parameter int PRESET_HI = 16
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst_n,
    input logic [CW-1:0] word_cnt,
    input logic [CW-1:0] free_cnt,
    input logic          almost_empty_n,
    input logic          almost_full_n,
    input logic [OW-1:0] x_off,
    input logic [OW-1:0] y_off,
    input logic          cfg_done,
    input cfg_mode_e     cfg_mode
);
    a_r8_full_follows: assert property (@(posedge clk_a) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |->
        (almost_full_n == !($past(free_cnt, 2) <= CW'($past(y_off, 2)))));

    a_r7_empty_follows: assert property (@(posedge clk_b) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |->
        (almost_empty_n == !($past(word_cnt, 2) <= CW'($past(x_off, 2)))));

    a_r1_mode_held: assert property (@(posedge clk_a) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_mode));

    a_r2_preset_hi: assert property (@(posedge clk_a) disable iff (!rst_n)
        (cfg_mode == MODE_PRESET_HI) |-> (x_off == OW'(PRESET_HI) && y_off == OW'(PRESET_HI)));

    a_r6_offsets_frozen: assert property (@(posedge clk_a) disable iff (!rst_n)
        (cfg_done && $past(cfg_done)) |-> ($stable(x_off) && $stable(y_off)));

    a_r4_done_sticky: assert property (@(posedge clk_a) disable iff (!rst_n)
        $past(cfg_done) |-> cfg_done);
endmodule

bind almost_flag_offsets almost_flag_offsets_chk #(.CW(CW), .OW(OW), .PRESET_HI(PRESET_HI)) i_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .word_cnt(word_cnt), .free_cnt(free_cnt),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n), .x_off(x_off),
    .y_off(y_off), .cfg_done(cfg_done), .cfg_mode(cfg_mode)
);

// File: tb/test_almost_flag_offsets.sv
// Bench: small configuration (DEPTH 32, 5-bit offsets), full count sweeps.
module test_almost_flag_offsets;
    localparam int DW = 36;
    localparam int DEPTH = 32;
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int OW = $clog2(DEPTH);

    logic clk_a = 0, clk_b = 0, rst_n = 0;
    logic sel_hi_sen_n = 1, sel_lo_sdat = 0, a_wr = 0;
    logic [DW-1:0] a_data = '0;
    logic [CW-1:0] word_cnt = '0, free_cnt = '0;
    logic a_fifo_wr, almost_empty_n, almost_full_n;
    int checks = 0, failures = 0;

    always #4 clk_a = ~clk_a;
    always #6 clk_b = ~clk_b;

    almost_flag_offsets #(.DW(DW), .DEPTH(DEPTH), .PRESET_LO(8), .PRESET_HI(16)) i_almost_flag_offsets (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel_hi_sen_n(sel_hi_sen_n),
        .sel_lo_sdat(sel_lo_sdat), .a_wr(a_wr), .a_data(a_data), .word_cnt(word_cnt),
        .free_cnt(free_cnt), .a_fifo_wr(a_fifo_wr), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n)
    );

    task automatic check(input logic act, input logic exp, input string msg);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", msg, act, exp);
        end
    endtask

    task automatic do_reset(input logic hi, input logic lo);
        @(negedge clk_a);
        rst_n = 0; sel_hi_sen_n = hi; sel_lo_sdat = lo; a_wr = 0;
        repeat (4) @(negedge clk_b);
        check(almost_empty_n, 1'b0, "R9 empty flag low in reset");
        check(almost_full_n, 1'b0, "R9 full flag low in reset");
        @(negedge clk_a);
        rst_n = 1; sel_hi_sen_n = 1;
    endtask

    task automatic sweep_full(input int yexp, input string tag);
        for (int c = 0; c <= DEPTH; c++) begin
            @(negedge clk_a); free_cnt = CW'(c);
            @(negedge clk_a); @(negedge clk_a);
            check(almost_full_n, !(c <= yexp), $sformatf("R8 %s free=%0d", tag, c));
        end
    endtask

    task automatic sweep_empty(input int xexp, input string tag);
        for (int c = 0; c <= DEPTH; c++) begin
            @(negedge clk_b); word_cnt = CW'(c);
            @(negedge clk_b); @(negedge clk_b);
            check(almost_empty_n, !(c <= xexp), $sformatf("R7 %s words=%0d", tag, c));
        end
    endtask

    task automatic a_write(input logic [DW-1:0] d, input logic exp_fwd, input string tag);
        @(negedge clk_a); a_wr = 1; a_data = d;
        #1 check(a_fifo_wr, exp_fwd, tag);
        @(negedge clk_a); a_wr = 0;
    endtask

    task automatic shift_bits(input logic [2*OW-1:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk_a); sel_hi_sen_n = 0; sel_lo_sdat = bits[i];
        end
        @(negedge clk_a); sel_hi_sen_n = 1;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R2 preset-low; R1 pins moved to the serial code after reset must not matter
        do_reset(1'b1, 1'b0);
        sel_hi_sen_n = 0; sel_lo_sdat = 1;
        sweep_full(8, "R1 R2 preset-lo");
        sweep_empty(8, "R1 R2 preset-lo");
        sel_hi_sen_n = 1;
        a_write(36'h1, 1'b1, "R4 preset forwards at once");

        // R2 preset-high
        do_reset(1'b1, 1'b1);
        sel_lo_sdat = 0;
        sweep_full(16, "R2 preset-hi");
        sweep_empty(16, "R2 preset-hi");

        // R3 parallel: R9 zero offsets first, then two loading writes
        do_reset(1'b0, 1'b1);
        sweep_full(0, "R9 parallel unprogrammed");
        a_write(36'hABCDEF005, 1'b0, "R4 R3 first write held (Y)");
        a_write(36'h987654334, 1'b0, "R4 R3 second write held (X)");
        a_write(36'h000000001, 1'b1, "R4 third write forwarded");
        sweep_full(5, "R3 parallel Y");
        sweep_empty(20, "R3 parallel X");

        // R5 serial: Y=13 then X=27, MSB first; R6 extra pulses ignored
        do_reset(1'b0, 1'b0);
        a_write(36'h1, 1'b0, "R4 serial write held");
        shift_bits({5'd13, 5'd27}, 2 * OW);
        shift_bits({5'd0, 5'd0}, 5);
        sweep_full(13, "R5 R6 serial Y");
        sweep_empty(27, "R5 R6 serial X");
        a_write(36'h1, 1'b1, "R4 serial done forwards");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule